// File: doc/BRIEF.md
# Conditional Branch-to-Link Resolver

This block is the execute-stage resolver for one conditional "branch to link register" instruction of a 32-bit fixed-length RISC instruction set. On each cycle in which the valid strobe is high it takes the instruction word, the current instruction address, the condition register and the count and link registers. It pulls out the branch-options and bit-select fields and decides whether the branch is taken. One cycle later it presents the next instruction address, a taken flag, and the write-enables and new values for the count and link registers.

The count register may be decremented and tested against zero in the same step as a test of one chosen condition-register bit. The branch target comes from the link register value presented with the instruction. A new link value, the return address, is written back alongside it. Any word that is not this instruction is flagged as an error and has no architectural effect.

Bit numbering follows the instruction set: bit 0 of a field is its most significant bit. Field bit k of the 32-bit word is port bit `insn[31-k]`.

Top module: `brlr_resolver`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid`, `taken`, `ctr_we`, `lr_we` and `bad_insn` are 0 and `nia` is 0.
- R2: `out_valid` is high exactly one cycle after `in_valid` was high. After a cycle with `in_valid` low, `taken`, `ctr_we`, `lr_we` and `bad_insn` are 0.
- R3: A word is recognised only when `insn[31:26]` equals 19 and `insn[10:1]` equals 16. For any other valid word the next cycle shows `bad_insn`=1, `taken`=0, `ctr_we`=0, `lr_we`=0 and `nia` = `cia`+4.
- R4: The branch-options field is BO = `insn[25:21]`, with BO[0] = `insn[25]` down to BO[4] = `insn[21]`. When BO[2] is 0 the block gives `ctr_we`=1 and `ctr_wdata` = `ctr_in`-1. When BO[2] is 1 it gives `ctr_we`=0.
- R5: The count test uses the value after the decrement. It passes when BO[2] is 1, or when (decremented count ≠ 0) XOR BO[3] is true.
- R6: The condition test passes when BO[0] is 1, or when the selected condition bit equals BO[1]. The bit index is BI = `insn[20:16]`. BI = 0 selects `cr[31]`, and in general BI selects `cr[31-BI]`.
- R7: `taken` is 1 only when both tests pass. Then `nia` is `lr_in` with its two low bits cleared. Otherwise `nia` = `cia`+4. When BO[0] and BO[2] are both 1, the branch is always taken.
- R8: When LK = `insn[0]` is 1, `lr_we`=1 and `lr_wdata` = `cia`+4. The target still comes from the `lr_in` value presented with the same instruction.
- R9: BO[4] has no effect. Two words that differ only in `insn[21]` give identical outputs.
- R10: The count decrement wraps, so a count of 0 becomes all ones. With BO[2]=0, BO[3]=0 and a count of 1, the count becomes 0 and the branch is not taken.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| insn | input | 32 | Instruction word |
| cia | input | ADDR_W | Address of the instruction |
| cr | input | CR_W | Condition register |
| ctr_in | input | CNT_W | Current count register |
| lr_in | input | ADDR_W | Current link register |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| nia | output | ADDR_W | Next instruction address |
| taken | output | 1 | Branch taken |
| ctr_we | output | 1 | Count register write enable |
| ctr_wdata | output | CNT_W | New count register value |
| lr_we | output | 1 | Link register write enable |
| lr_wdata | output | ADDR_W | New link register value |
| bad_insn | output | 1 | Word was not this instruction |

## Verification
The bench first applies named branch-option patterns, each of which separates one decision from the others:
- the always-taken return with a misaligned link value, which shows the target masking;
- the same word with the hint bit flipped, which shows the hint is ignored;
- condition-only tests at BI = 0 and BI = 2 with the bit both set and clear, which show the bit ordering and the polarity;
- count-only tests at counts 0, 1 and 5 under both zero polarities, which show that the test uses the post-decrement value and that the decrement wraps.

Combined count-and-condition cases show that both tests must pass. Link-setting words show that the target comes from the old link value. Words with a wrong primary or extended opcode show that they have no effect.

A long run of random recognised words is then compared, cycle by cycle, against the behavioural model.

// File: rtl/brlr_pkg.sv
package brlr_pkg;
  localparam int INSN_W     = 32;
  localparam int PRIM_W     = 6;
  localparam int EXT_W      = 10;
  localparam int FLD_W      = 5;
  localparam logic [PRIM_W-1:0] PRIM_OP = 6'd19;
  localparam logic [EXT_W-1:0]  EXT_OP  = 10'd16;

  typedef struct packed {
    logic             no_cond;   // skip condition test
    logic             cond_want; // required value of selected bit
    logic             no_count;  // skip count decrement and test
    logic             want_zero; // count test polarity
    logic [FLD_W-1:0] bit_sel;   // condition bit index, 0 = MSB
    logic             link;      // write return address
  } brlr_fields_t;
endpackage

// File: rtl/brlr_decode.sv
module brlr_decode
  import brlr_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output brlr_fields_t      fields,
  output logic              match
);
  logic [PRIM_W-1:0] prim;
  logic [EXT_W-1:0]  ext;
  logic              unused_bits;

  assign prim = insn[31:26];
  assign ext  = insn[10:1];
  assign match = (prim == PRIM_OP) && (ext == EXT_OP);

  always_comb begin
    fields.no_cond   = insn[25];
    fields.cond_want = insn[24];
    fields.no_count  = insn[23];
    fields.want_zero = insn[22];
    fields.bit_sel   = insn[20:16];
    fields.link      = insn[0];
  end

  // prediction hint and the unused source field carry no behaviour
  assign unused_bits = &{1'b0, insn[21], insn[15:11]};
endmodule

// File: rtl/brlr_count_unit.sv
module brlr_count_unit #(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0] count,
  input  logic             no_count,
  input  logic             want_zero,
  output logic [CNT_W-1:0] count_next,
  output logic             dec_en,
  output logic             count_ok
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic nonzero;

  assign dec_en     = !no_count;
  assign count_next = count - ONE;
  assign nonzero    = |count_next;
  assign count_ok   = no_count || (nonzero ^ want_zero);
endmodule

// File: rtl/brlr_cond_unit.sv
module brlr_cond_unit #(
  parameter int CR_W  = 32,
  parameter int FLD_W = 5
) (
  input  logic [CR_W-1:0]  cr,
  input  logic [FLD_W-1:0] bit_sel,
  input  logic             no_cond,
  input  logic             cond_want,
  output logic             cond_ok
);
  localparam int SEL_W = $clog2(CR_W);

  logic [CR_W-1:0]  cr_rev;
  logic [SEL_W-1:0] idx;
  logic             picked;

  // reverse so that index 0 addresses the most significant bit
  for (genvar g = 0; g < CR_W; g++) begin : g_rev
    assign cr_rev[g] = cr[CR_W-1-g];
  end

  assign idx     = bit_sel[SEL_W-1:0];
  assign picked  = cr_rev[idx];
  assign cond_ok = no_cond || (picked == cond_want);
endmodule

// File: rtl/brlr_resolver.sv
module brlr_resolver
  import brlr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int CR_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] insn,
  input  logic [ADDR_W-1:0] cia,
  input  logic [CR_W-1:0]   cr,
  input  logic [CNT_W-1:0]  ctr_in,
  input  logic [ADDR_W-1:0] lr_in,
  output logic              out_valid,
  output logic [ADDR_W-1:0] nia,
  output logic              taken,
  output logic              ctr_we,
  output logic [CNT_W-1:0]  ctr_wdata,
  output logic              lr_we,
  output logic [ADDR_W-1:0] lr_wdata,
  output logic              bad_insn
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  brlr_fields_t      f;
  logic              match;
  logic [CNT_W-1:0]  cnt_next;
  logic              dec_en;
  logic              count_ok;
  logic              cond_ok;
  logic              take_c;
  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] target;
  logic              unused_lr;

  brlr_decode u_dec (
    .insn   (insn),
    .fields (f),
    .match  (match)
  );

  brlr_count_unit #(.CNT_W(CNT_W)) u_cnt (
    .count      (ctr_in),
    .no_count   (f.no_count),
    .want_zero  (f.want_zero),
    .count_next (cnt_next),
    .dec_en     (dec_en),
    .count_ok   (count_ok)
  );

  brlr_cond_unit #(.CR_W(CR_W), .FLD_W(FLD_W)) u_cond (
    .cr        (cr),
    .bit_sel   (f.bit_sel),
    .no_cond   (f.no_cond),
    .cond_want (f.cond_want),
    .cond_ok   (cond_ok)
  );

  assign take_c    = match && count_ok && cond_ok;
  assign seq_addr  = cia + STEP;
  assign target    = {lr_in[ADDR_W-1:2], 2'b00};
  assign unused_lr = &{1'b0, lr_in[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      ctr_we    <= 1'b0;
      lr_we     <= 1'b0;
      bad_insn  <= 1'b0;
      nia       <= '0;
      ctr_wdata <= '0;
      lr_wdata  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken     <= take_c;
        ctr_we    <= match && dec_en;
        lr_we     <= match && f.link;
        bad_insn  <= !match;
        nia       <= take_c ? target : seq_addr;
        ctr_wdata <= cnt_next;
        lr_wdata  <= seq_addr;
      end else begin
        taken    <= 1'b0;
        ctr_we   <= 1'b0;
        lr_we    <= 1'b0;
        bad_insn <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/brlr_resolver_chk.sv
module brlr_resolver_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int CR_W   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [31:0]       insn,
  input logic [ADDR_W-1:0] cia,
  input logic [CR_W-1:0]   cr,
  input logic [CNT_W-1:0]  ctr_in,
  input logic [ADDR_W-1:0] lr_in,
  input logic              out_valid,
  input logic [ADDR_W-1:0] nia,
  input logic              taken,
  input logic              ctr_we,
  input logic [CNT_W-1:0]  ctr_wdata,
  input logic              lr_we,
  input logic [ADDR_W-1:0] lr_wdata,
  input logic              bad_insn
);
  logic is_br;
  assign is_br = (insn[31:26] == 6'd19) && (insn[10:1] == 10'd16);

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == ($past(in_valid) && !$past(rst)));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !(taken || ctr_we || lr_we || bad_insn));

  // R3
  bad_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
    bad_insn |-> !(taken || ctr_we || lr_we));

  // R3
  bad_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_br) |=> bad_insn);

  // R4
  dec_value_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_br && !insn[23]) |=> (ctr_we && ctr_wdata == $past(ctr_in) - CNT_W'(1)));

  // R7
  always_branch_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_br && insn[25] && insn[23]) |=> taken);

  // R7
  target_align_chk: assert property (@(posedge clk) disable iff (rst)
    taken |-> (nia[1:0] == 2'b00));

  // R8
  link_value_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_br && insn[0]) |=> (lr_we && lr_wdata == $past(cia) + ADDR_W'(4)));
endmodule

bind brlr_resolver brlr_resolver_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CR_W(CR_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .cia(cia),
  .cr(cr), .ctr_in(ctr_in), .lr_in(lr_in), .out_valid(out_valid),
  .nia(nia), .taken(taken), .ctr_we(ctr_we), .ctr_wdata(ctr_wdata),
  .lr_we(lr_we), .lr_wdata(lr_wdata), .bad_insn(bad_insn)
);

// File: tb/brlr_resolver_bench.sv
`timescale 1ns/1ps
module brlr_resolver_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [31:0] cia = '0;
  logic [31:0] cr = '0;
  logic [31:0] ctr_in = '0;
  logic [31:0] lr_in = '0;
  logic        out_valid, taken, ctr_we, lr_we, bad_insn;
  logic [31:0] nia, ctr_wdata, lr_wdata;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // expected results
  bit          e_v, e_t, e_cwe, e_lwe, e_bad;
  logic [31:0] e_nia, e_ctr, e_lr;

  always #4 clk = ~clk;

  brlr_resolver u_brlr_resolver (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .cia(cia),
    .cr(cr), .ctr_in(ctr_in), .lr_in(lr_in), .out_valid(out_valid),
    .nia(nia), .taken(taken), .ctr_we(ctr_we), .ctr_wdata(ctr_wdata),
    .lr_we(lr_we), .lr_wdata(lr_wdata), .bad_insn(bad_insn)
  );

  function automatic logic [31:0] mk(input logic [4:0] bo, input logic [4:0] bi,
                                     input logic lk);
    return {6'd19, bo, bi, 5'd0, 10'd16, lk};
  endfunction

  // field bit k counted from the MSB of the word
  function automatic bit fb(input logic [31:0] w, input int k);
    return w[31-k];
  endfunction

  task automatic model(input bit v, input logic [31:0] w, input logic [31:0] a,
                       input logic [31:0] c, input logic [31:0] n, input logic [31:0] l);
    bit ok_br, ctr_pass, cond_pass;
    logic [31:0] n2;
    int bi;
    e_v = v; e_t = 0; e_cwe = 0; e_lwe = 0; e_bad = 0;
    if (!v) return;
    ok_br = (w[31:26] == 19) && (w[10:1] == 16);
    e_nia = a + 4;
    e_lr  = a + 4;
    if (!ok_br) begin
      e_bad = 1;
      return;
    end
    n2 = n;
    if (!fb(w, 8)) begin
      n2 = n - 1;
      e_cwe = 1;
    end
    e_ctr = n2;
    ctr_pass = fb(w, 8) || ((n2 != 0) != fb(w, 9));
    bi = int'(w[20:16]);
    cond_pass = fb(w, 6) || (c[31-bi] == fb(w, 7));
    if (ctr_pass && cond_pass) begin
      e_t = 1;
      e_nia = l & 32'hFFFF_FFFC;
    end
    e_lwe = fb(w, 31);
  endtask

  task automatic compare(input string tag);
    bit bad;
    tests++;
    bad = (out_valid !== e_v) || (taken !== e_t) || (ctr_we !== e_cwe) ||
          (lr_we !== e_lwe) || (bad_insn !== e_bad);
    if (e_v && nia !== e_nia) bad = 1;
    if (e_cwe && ctr_wdata !== e_ctr) bad = 1;
    if (e_lwe && lr_wdata !== e_lr) bad = 1;
    if (bad) begin
      fails++;
      $display("FAIL %s: got v%0b t%0b cwe%0b lwe%0b bad%0b nia=%h ctr=%h lr=%h exp v%0b t%0b cwe%0b lwe%0b bad%0b nia=%h ctr=%h lr=%h",
               tag, out_valid, taken, ctr_we, lr_we, bad_insn, nia, ctr_wdata, lr_wdata,
               e_v, e_t, e_cwe, e_lwe, e_bad, e_nia, e_ctr, e_lr);
    end
  endtask

  // drive at a falling edge, result sampled at the next falling edge
  task automatic step(input string tag, input bit v, input logic [31:0] w,
                      input logic [31:0] a, input logic [31:0] c,
                      input logic [31:0] n, input logic [31:0] l);
    in_valid = v; insn = w; cia = a; cr = c; ctr_in = n; lr_in = l;
    model(v, w, a, c, n, l);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL R2: watchdog expired, got hang exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [31:0] a;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    e_v = 0; e_t = 0; e_cwe = 0; e_lwe = 0; e_bad = 0;
    tests++;
    if (out_valid !== 0 || taken !== 0 || ctr_we !== 0 || lr_we !== 0 ||
        bad_insn !== 0 || nia !== 0) begin
      fails++;
      $display("FAIL R1: got v%0b t%0b nia=%h exp all zero", out_valid, taken, nia);
    end
    rst = 1'b0;
    step("R1", 0, '0, '0, '0, '0, '0);

    // R7 always-taken return, misaligned link value masked
    step("R7", 1, mk(5'b10100, 5'd0, 0), 32'h100, 0, 32'd7, 32'h0000_1003);
    step("R2", 0, '0, 32'h104, 0, 0, 0);
    // R9 hint bit flipped
    step("R9", 1, mk(5'b10101, 5'd0, 0), 32'h100, 0, 32'd7, 32'h0000_1003);
    // R6 bit 2 set / clear, branch if true
    step("R6", 1, mk(5'b01100, 5'd2, 0), 32'h200, 32'h2000_0000, 0, 32'h4000);
    step("R6", 1, mk(5'b01100, 5'd2, 0), 32'h200, 32'hDFFF_FFFF, 0, 32'h4000);
    // R6 branch if false
    step("R6", 1, mk(5'b00100, 5'd2, 0), 32'h200, 32'h0000_0000, 0, 32'h4000);
    // R6 BI=0 picks MSB
    step("R6", 1, mk(5'b01100, 5'd0, 0), 32'h300, 32'h8000_0000, 0, 32'h5000);
    step("R6", 1, mk(5'b01100, 5'd0, 0), 32'h300, 32'h0000_0001, 0, 32'h5000);
    step("R6", 1, mk(5'b01100, 5'd31, 0), 32'h300, 32'h0000_0001, 0, 32'h5000);
    // R10 count 1 reaches zero, not taken
    step("R10", 1, mk(5'b10000, 5'd0, 0), 32'h400, 0, 32'd1, 32'h6000);
    step("R10", 1, mk(5'b00000, 5'd3, 0), 32'h400, 0, 32'd1, 32'h6000);
    // R5 count 5, branch if nonzero
    step("R5", 1, mk(5'b10000, 5'd0, 0), 32'h400, 0, 32'd5, 32'h6000);
    // R5 branch if zero after decrement
    step("R5", 1, mk(5'b10010, 5'd0, 0), 32'h400, 0, 32'd1, 32'h6000);
    step("R5", 1, mk(5'b10010, 5'd0, 0), 32'h400, 0, 32'd2, 32'h6000);
    // R10 wrap from zero
    step("R10", 1, mk(5'b10000, 5'd0, 0), 32'h400, 0, 32'd0, 32'h6000);
    // R4 no decrement when BO[2]=1
    step("R4", 1, mk(5'b00110, 5'd4, 0), 32'h500, 0, 32'd9, 32'h7000);
    // R5/R6 combined: both must pass
    step("R5", 1, mk(5'b00000, 5'd4, 0), 32'h500, 32'h0000_0000, 32'd3, 32'h7000);
    step("R6", 1, mk(5'b00000, 5'd4, 0), 32'h500, 32'h0800_0000, 32'd3, 32'h7000);
    // R8 link: target from old link value
    step("R8", 1, mk(5'b10100, 5'd0, 1), 32'h800, 0, 0, 32'h9000);
    step("R8", 1, mk(5'b01100, 5'd1, 1), 32'h804, 32'h0, 0, 32'h9000);
    // R3 wrong primary / extended opcode
    w = mk(5'b10100, 5'd0, 1); w[31:26] = 6'd18;
    step("R3", 1, w, 32'hA00, 0, 32'd4, 32'hB000);
    w = mk(5'b10000, 5'd0, 1); w[10:1] = 10'd528;
    step("R3", 1, w, 32'hA04, 0, 32'd4, 32'hB000);
    step("R2", 0, '0, 0, 0, 0, 0);

    // R5 random recognised words, model compared every clock
    for (int i = 0; i < 400; i++) begin
      w = mk(5'($urandom), 5'($urandom), 1'($urandom));
      if ((i % 17) == 0) w[31:26] = 6'($urandom);
      a = $urandom & 32'hFFFF_FFFC;
      step("R5", ($urandom % 5) != 0, w, a, $urandom, $urandom % 4, $urandom);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule